// File: doc/BRIEF.md
# Switch Host Control Port

This block sits between an 8-bit asynchronous processor bus and the storage of a time-slot switch. The processor sees the switch as a small memory peripheral. One half of the six-bit address space reaches a single control byte; the other half reaches 32 channel locations. Which memory and which stream those channel locations belong to is taken from the control byte, so each channel access is addressed by combining the paged bits of the control byte with the five channel bits from the bus.

The bus strobes are brought into the internal clock domain through a synchronizer. A write to the control byte finishes immediately. Every other access waits. A control read takes one extra cycle. A memory access holds until the serial side offers a free access slot, and only then is a single request issued to the memory ports.

Two modes held in the control byte change how the memories are reached. In split mode, reads always go to the data memory and writes always go to connection memory low, whatever the select bits say. Broadcast mode is passed on to the serial side, which uses it to place every output channel in message mode. Completion is shown on an open-drain acknowledge, modelled here as a pull-low enable. It stays asserted until the processor ends the cycle.

Top module: `swctl_host_port`

## Requirements
- R1: After reset the acknowledge pull, the memory request, the read-data drive enable and the broadcast output are all 0, and the control byte reads back as 0x00.
- R2: An access is taken when chip select is low and data strobe is high. With address bit 5 at 0 it targets the control byte, whatever address bits 4..0 hold. A control write stores the byte and raises the acknowledge on the third clock edge after the strobe becomes active. It issues no memory request.
- R3: A control read raises the acknowledge on the fourth clock edge after the strobe becomes active and returns the control byte on the bus read data. The read-data drive enable is 1 only while a read is being acknowledged.
- R4: With address bit 5 at 1, the memory request carries channel = address bits 4..0 and stream = control bits 1..0. The memory select comes from control bits 4..3, coded 00 data memory, 10 connection low and 11 connection high; code 01 is treated as the data memory. The request also carries write enable = not read/write (read/write is 1 for read) and write data = the bus data.
- R5: A memory access enters a wait state on the third edge after the strobe. It raises the memory request only in a cycle where the slot input is 1. The acknowledge follows one edge after the granted cycle for a write and two edges after it for a read. Read data is the memory read data present in the cycle after the grant.
- R6: When control bit 7 (split) is 1, a memory read selects the data memory (00) and a memory write selects connection low (10), regardless of control bits 4..3.
- R7: The broadcast output equals control bit 6 and changes only as a result of a control write.
- R8: The acknowledge stays asserted for as long as chip select stays low and data strobe stays high. It drops on the third edge after either one goes inactive, and a held strobe never starts a second access.
- R9: The memory request is 0 whenever no memory access is waiting, including cycles where the slot input is 1. It is never 1 in two consecutive cycles.
- R10: While chip select is high the bus is ignored. No acknowledge is given and the control byte keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low, asynchronous |
| bus_ds | input | 1 | Data strobe, active high, asynchronous |
| bus_rd_wr | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 6 | Bus address; bit 5 picks control byte (0) or channel (1) |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data towards the processor |
| bus_rdata_oe | output | 1 | Read data drive enable |
| bus_ack_pull | output | 1 | 1 pulls the open-drain acknowledge low |
| mem_slot | input | 1 | Serial side offers a free access slot this cycle |
| mem_req | output | 1 | Memory access issued this cycle |
| mem_we | output | 1 | Issued access is a write |
| mem_sel | output | 2 | Target memory: 00 data, 10 connection low, 11 connection high |
| mem_stream | output | 2 | Stream number of the access |
| mem_chan | output | 5 | Channel number of the access |
| mem_wdata | output | 8 | Write data of the access |
| mem_rdata | input | 8 | Memory read data, valid the cycle after a granted read |
| bcast_en | output | 1 | Broadcast mode towards the serial side |

## Verification
A free slot from the serial side can arrive in the very cycle the port decodes a control-byte access, and in any cycle while an acknowledge is still held. The bench holds the slot input at 1 through whole control reads and writes and through long acknowledge holds. The reference model then expects the memory request to stay at 0 and the acknowledge timing to be unchanged. A grant can also land in the first wait cycle or several cycles later. Each case is judged by comparing the acknowledge, the request and its fields against the model on every clock.

// File: rtl/swctl_pkg.sv
// Shared types and control-byte field positions for the switch host port.
// Assumes an 8-bit control byte; field positions are fixed behaviour.
package swctl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL_RD,
        ST_WAIT_SLOT,
        ST_MEM_RD,
        ST_DONE
    } acc_state_t;

    typedef enum logic [1:0] {
        MEM_DATA    = 2'b00,
        MEM_RSVD    = 2'b01,
        MEM_CONN_LO = 2'b10,
        MEM_CONN_HI = 2'b11
    } mem_sel_t;

    localparam int CTRL_SPLIT_BIT = 7;
    localparam int CTRL_BCAST_BIT = 6;
    localparam int CTRL_SEL_HI    = 4;
    localparam int CTRL_SEL_LO    = 3;
endpackage

// File: rtl/swctl_sync.sv
// Multi-stage synchronizer for asynchronous single-bit bus controls.
// Assumes each bit is independent; STAGES >= 2.
module swctl_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the raw bit through the stage chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_async[gi]};
        end
        assign q_sync[gi] = chain[STAGES-1];
    end
endmodule

// File: rtl/swctl_addr_map.sv
// Forms the memory select and stream of a channel access from the control
// byte, applying split mode. Assumes STREAM_W <= 3 (stream bits below select).
module swctl_addr_map
    import swctl_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int STREAM_W = 2
) (
    input  logic [DATA_W-1:0]   ctrl,
    input  logic                is_write,
    output logic [1:0]          sel,
    output logic [STREAM_W-1:0] stream
);
    logic [1:0] paged_sel;

    assign paged_sel = ctrl[CTRL_SEL_HI:CTRL_SEL_LO];
    assign stream    = ctrl[STREAM_W-1:0];

    // Pick the target memory; split mode overrides the paged select.
    always_comb begin
        if (ctrl[CTRL_SPLIT_BIT])
            sel = is_write ? MEM_CONN_LO : MEM_DATA;
        else if (paged_sel == MEM_RSVD)
            sel = MEM_DATA;
        else
            sel = paged_sel;
    end
endmodule

// File: rtl/swctl_access_fsm.sv
// Access sequencer: decodes control versus channel space, holds the control
// byte, waits for a slot, captures read data and drives the acknowledge.
// Assumes address, direction and write data are stable while the strobe is active.
module swctl_access_fsm
    import swctl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_act,
    input  logic              bus_is_read,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              mem_slot,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              lat_write,
    output logic [DATA_W-1:0] lat_wdata,
    output logic              mem_req,
    output logic              ack,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rdata_oe
);
    localparam int SPACE_BIT = ADDR_W - 1;

    acc_state_t state;

    // Sequence one bus access from decode to release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ctrl_q    <= '0;
            lat_addr  <= '0;
            lat_write <= 1'b0;
            lat_wdata <= '0;
            rdata_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (bus_act) begin
                    lat_addr  <= bus_addr;
                    lat_write <= !bus_is_read;
                    lat_wdata <= bus_wdata;
                    if (!bus_addr[SPACE_BIT]) begin
                        if (!bus_is_read) begin
                            ctrl_q <= bus_wdata;
                            state  <= ST_DONE;
                        end else begin
                            state  <= ST_CTRL_RD;
                        end
                    end else begin
                        state <= ST_WAIT_SLOT;
                    end
                end
                ST_CTRL_RD: begin
                    rdata_q <= ctrl_q;
                    state   <= ST_DONE;
                end
                ST_WAIT_SLOT: if (mem_slot) begin
                    state <= lat_write ? ST_DONE : ST_MEM_RD;
                end
                ST_MEM_RD: begin
                    rdata_q <= mem_rdata;
                    state   <= ST_DONE;
                end
                ST_DONE: if (!bus_act) begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Request, acknowledge and read drive follow the current state.
    always_comb begin
        mem_req  = (state == ST_WAIT_SLOT) && mem_slot;
        ack      = (state == ST_DONE);
        rdata_oe = ack && !lat_write;
    end
endmodule

// File: rtl/swctl_host_port.sv
// Top of the switch host port: synchronizes the bus strobes, sequences
// accesses and forms memory addresses. Assumes an external pull-up on the
// acknowledge and memories that return read data one cycle after a request.
module swctl_host_port
    import swctl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 6,
    parameter int STREAM_W    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_cs_n,
    input  logic                bus_ds,
    input  logic                bus_rd_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rdata_oe,
    output logic                bus_ack_pull,
    input  logic                mem_slot,
    output logic                mem_req,
    output logic                mem_we,
    output logic [1:0]          mem_sel,
    output logic [STREAM_W-1:0] mem_stream,
    output logic [ADDR_W-2:0]   mem_chan,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                bcast_en
);
    localparam int CHAN_W = ADDR_W - 1;

    logic [1:0]        strobe_sync;
    logic              bus_act;
    logic [DATA_W-1:0] ctrl_q;
    logic [ADDR_W-1:0] lat_addr;
    logic              lat_write;

    swctl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({!bus_cs_n, bus_ds}),
        .q_sync  (strobe_sync)
    );

    assign bus_act = strobe_sync[1] && strobe_sync[0];

    swctl_access_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_act     (bus_act),
        .bus_is_read (bus_rd_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .mem_slot    (mem_slot),
        .mem_rdata   (mem_rdata),
        .ctrl_q      (ctrl_q),
        .lat_addr    (lat_addr),
        .lat_write   (lat_write),
        .lat_wdata   (mem_wdata),
        .mem_req     (mem_req),
        .ack         (bus_ack_pull),
        .rdata_q     (bus_rdata),
        .rdata_oe    (bus_rdata_oe)
    );

    swctl_addr_map #(.DATA_W(DATA_W), .STREAM_W(STREAM_W)) u_map (
        .ctrl     (ctrl_q),
        .is_write (lat_write),
        .sel      (mem_sel),
        .stream   (mem_stream)
    );

    assign mem_we   = lat_write;
    assign mem_chan = lat_addr[CHAN_W-1:0];
    assign bcast_en = ctrl_q[CTRL_BCAST_BIT];
endmodule

// File: rtl/swctl_host_port_chk.sv
// Property checker for the switch host port, bound to every instance.
module swctl_host_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_ack_pull,
    input logic              bus_rdata_oe,
    input logic              mem_req,
    input logic              mem_slot,
    input logic              mem_we,
    input logic [1:0]        mem_sel,
    input logic              bcast_en,
    input logic              bus_act,
    input logic [DATA_W-1:0] ctrl_q
);
    a_r5_req_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_slot);
    a_r9_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    a_r9_no_req_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack_pull |-> !mem_req);
    a_r3_oe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_oe |-> bus_ack_pull);
    a_r7_bcast_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bcast_en) |-> $rose(bus_ack_pull));
    a_r6_split_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && ctrl_q[7]) |-> (mem_sel == (mem_we ? 2'b10 : 2'b00)));
    a_r8_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ack_pull) |-> !$past(bus_act));
endmodule

bind swctl_host_port swctl_host_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_ack_pull (bus_ack_pull),
    .bus_rdata_oe (bus_rdata_oe),
    .mem_req      (mem_req),
    .mem_slot     (mem_slot),
    .mem_we       (mem_we),
    .mem_sel      (mem_sel),
    .bcast_en     (bcast_en),
    .bus_act      (bus_act),
    .ctrl_q       (ctrl_q)
);

// File: tb/swctl_host_port_bench.sv
module swctl_host_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs_n = 1'b1;
    logic       bus_ds = 1'b0;
    logic       bus_rd_wr = 1'b1;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rdata_oe;
    logic       bus_ack_pull;
    logic       mem_slot = 1'b0;
    logic       mem_req;
    logic       mem_we;
    logic [1:0] mem_sel;
    logic [1:0] mem_stream;
    logic [4:0] mem_chan;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;
    logic       bcast_en;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model_ctrl = 8'h00;
    logic       bg_slot = 1'b0;

    always #10 clk = ~clk;

    // Memory stand-in: read data is a function of the request fields.
    assign mem_rdata = {mem_sel, mem_chan, 1'b0} ^ 8'h3C ^ {6'b0, mem_stream};

    swctl_host_port u_swctl_host_port (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_ds(bus_ds),
        .bus_rd_wr(bus_rd_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
        .bus_ack_pull(bus_ack_pull), .mem_slot(mem_slot), .mem_req(mem_req),
        .mem_we(mem_we), .mem_sel(mem_sel), .mem_stream(mem_stream),
        .mem_chan(mem_chan), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .bcast_en(bcast_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_sel(input logic [7:0] c, input bit wr);
        if (c[7]) return wr ? 2'b10 : 2'b00;
        if (c[4:3] == 2'b01) return 2'b00;
        return c[4:3];
    endfunction

    // One bus access, compared against the timing model on every clock.
    task automatic access(input bit wr, input logic [5:0] a, input logic [7:0] d,
                          input int dly, input int hold, input string tag);
        bit   is_mem = a[5];
        int   ack_k = is_mem ? ((wr ? 4 : 5) + dly) : (wr ? 3 : 4);
        int   grant_k = 3 + dly;
        logic [1:0] es = exp_sel(model_ctrl, wr);
        logic [7:0] exp_rd;
        if (!is_mem) exp_rd = model_ctrl;
        else exp_rd = {es, a[4:0], 1'b0} ^ 8'h3C ^ {6'b0, model_ctrl[1:0]};
        @(negedge clk);
        bus_cs_n = 1'b0; bus_ds = 1'b1; bus_rd_wr = !wr; bus_addr = a; bus_wdata = d;
        mem_slot = is_mem ? 1'b0 : bg_slot;
        for (int k = 1; k <= ack_k + hold; k++) begin
            @(posedge clk); @(negedge clk);
            if (is_mem) mem_slot = (k == grant_k);
            #1;
            chk(bus_ack_pull == (k >= ack_k), tag, bus_ack_pull, k >= ack_k);
            if (is_mem && k == grant_k) begin
                chk(mem_req == 1'b1, "R5 grant", mem_req, 1);
                chk(mem_sel == es, model_ctrl[7] ? "R6 sel" : "R4 sel", mem_sel, es);
                chk(mem_chan == a[4:0], "R4 chan", mem_chan, a[4:0]);
                chk(mem_stream == model_ctrl[1:0], "R4 stream", mem_stream, model_ctrl[1:0]);
                chk(mem_we == wr, "R4 we", mem_we, wr);
                if (wr) chk(mem_wdata == d, "R4 wdata", mem_wdata, d);
            end else begin
                chk(mem_req == 1'b0, "R9 no req", mem_req, 0);
            end
            if (k >= ack_k)
                chk(bus_rdata_oe == !wr, "R3 oe", bus_rdata_oe, !wr);
            else
                chk(bus_rdata_oe == 1'b0, "R3 oe idle", bus_rdata_oe, 0);
            if (k >= ack_k && !wr)
                chk(bus_rdata == exp_rd, is_mem ? "R5 rdata" : "R3 rdata", bus_rdata, exp_rd);
        end
        if (!is_mem && wr) begin
            model_ctrl = d;
            chk(bcast_en == d[6], "R7 bcast", bcast_en, d[6]);
        end
        bus_ds = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            @(posedge clk); @(negedge clk); #1;
            chk(bus_ack_pull == (k < 3), "R8 release", bus_ack_pull, k < 3);
            chk(mem_req == 1'b0, "R9 release", mem_req, 0);
        end
        bus_cs_n = 1'b1;
        mem_slot = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(bus_ack_pull == 0, "R1 ack", bus_ack_pull, 0);
        chk(mem_req == 0, "R1 req", mem_req, 0);
        chk(bus_rdata_oe == 0, "R1 oe", bus_rdata_oe, 0);
        chk(bcast_en == 0, "R1 bcast", bcast_en, 0);
        access(0, 6'h00, 8'h00, 0, 0, "R1 ctrl read");

        bg_slot = 1'b1;
        access(1, 6'h00, 8'h1A, 0, 0, "R2 ctrl write");
        access(1, 6'h1F, 8'h12, 0, 2, "R2 ctrl write high bits");
        access(0, 6'h07, 8'h00, 0, 0, "R3 ctrl read");
        bg_slot = 1'b0;

        access(1, 6'h25, 8'h77, 0, 0, "R5 mem write");
        access(0, 6'h3F, 8'h00, 3, 4, "R8 mem read hold");
        access(1, 6'h00, 8'h19, 0, 0, "R2 ctrl write");
        access(0, 6'h20, 8'h00, 1, 0, "R5 mem read");
        access(1, 6'h3A, 8'hC3, 5, 0, "R5 mem write late");
        access(1, 6'h00, 8'h08, 0, 0, "R2 ctrl write");
        access(0, 6'h31, 8'h00, 0, 0, "R4 reserved select");

        bg_slot = 1'b1;
        access(1, 6'h00, 8'h9B, 0, 0, "R6 split on");
        bg_slot = 1'b0;
        access(0, 6'h2C, 8'h00, 2, 0, "R6 split read");
        access(1, 6'h2C, 8'h5A, 0, 0, "R6 split write");

        access(1, 6'h00, 8'h40, 0, 0, "R7 bcast on");
        access(0, 6'h11, 8'h00, 0, 0, "R7 read back");
        access(1, 6'h00, 8'h03, 0, 0, "R7 bcast off");

        // R10: strobe with chip select high is ignored.
        @(negedge clk);
        bus_cs_n = 1'b1; bus_ds = 1'b1; bus_rd_wr = 1'b0; bus_addr = 6'h00; bus_wdata = 8'hFF;
        mem_slot = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(posedge clk); @(negedge clk); #1;
            chk(bus_ack_pull == 0, "R10 no ack", bus_ack_pull, 0);
            chk(mem_req == 0, "R9 idle slot", mem_req, 0);
        end
        bus_ds = 1'b0; mem_slot = 1'b0;
        chk(bcast_en == 0, "R10 bcast kept", bcast_en, 0);
        access(0, 6'h00, 8'h00, 0, 0, "R10 ctrl unchanged");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule